// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block sits between a network controller's data paths and the host. Single-cycle event pulses from the receive, transmit and remote-transfer logic are caught in sticky bits of an 8-bit status register. The host clears those bits by writing ones to them. A 7-bit mask decides which of the sticky bits raise the single interrupt line. Three tally counters record alignment errors, CRC errors and missed frames. Each counter clears when it is read and stops at its top value. When the top bit of any counter is set, a counter-overflow status bit is raised.

The block also holds the run/halt control state. A halt command takes the controller offline, but the halt is only confirmed once the frame in flight has finished. The confirmation is a read-only status bit, which is also raised when the receive ring is overwritten. A start command clears that bit. When the bit was raised only by an overwrite, freeing a ring entry also clears it.

The host uses a plain register bus. Writes take effect at the clock edge. Read data is combinational from the address. The register map is: 0 control, 1 status, 2 mask, 3 alignment tally, 4 CRC tally, 5 missed tally.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status register (address 1) reads 0x80, the mask (address 2) reads 0x00, all three tallies read 0, irq is low, running is low and control (address 0) reads 0x01.
- R2: Each event pulse sets its own sticky status bit: bit0 rx_ok, bit1 tx_ok, bit2 rx_err, bit3 tx_err, bit4 ring_ovw, bit6 xfer_done. Each bit stays set until the host clears it.
- R3: Writing 1 to status bits 0–6 clears them. Writing 0 leaves a bit unchanged, and writing bit7 has no effect. An event in the same cycle as its clear leaves the bit set.
- R4: Mask bits 0–6 are read/write at the same positions as the status bits. Mask bit 7 always reads 0.
- R5: irq is high exactly when some status bit 0–6 is set together with its mask bit. Status bit 7 never drives irq.
- R6: Each tally counter (3 alignment, 4 CRC, 5 missed) increments once per cycle its input is high and saturates at 0xFF.
- R7: Reading a tally returns its value and clears it. An increment in the same cycle as the read leaves the counter at 1.
- R8: Status bit5 is set whenever the top bit of any tally is set. Writing 1 to bit5 does not clear it while such a top bit remains set.
- R9: Writing control with bit1=1 and bit0=0 (start) sets running and clears status bit7. Control then reads 0x02.
- R10: Writing control with bit0=1 (halt) clears running at once and reads 0x05 while frame_busy holds. Status bit7 sets one edge after frame_busy is low, and control then reads 0x01.
- R11: A ring_ovw pulse sets status bits 4 and 7. A ring_freed pulse then clears bit7 unless a confirmed halt also holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears tallies) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ev_rx_ok | input | 1 | Frame received without error |
| ev_tx_ok | input | 1 | Frame sent without error |
| ev_rx_err | input | 1 | Receive error (CRC, alignment, overrun, missed) |
| ev_tx_err | input | 1 | Transmit error (excess collisions, underrun) |
| ev_ring_ovw | input | 1 | Receive ring overwrite |
| ev_xfer_done | input | 1 | Remote transfer complete |
| tally_align | input | 1 | Alignment-error increment |
| tally_crc | input | 1 | CRC-error increment |
| tally_miss | input | 1 | Missed-frame increment |
| frame_busy | input | 1 | A frame is in progress |
| ring_freed | input | 1 | A frame was removed from the ring |
| irq | output | 1 | Interrupt request |
| running | output | 1 | Controller is online |

## Verification
A corrupted sticky bit or mask bit shows on the next status or mask read. When the mask enables that bit, it also shows on irq in the same cycle as the bad edge. A counter that fails to saturate or to clear shows as a wrong value on the following tally read. It also shows through bit5, which a clear write cannot remove while a top bit stays set. Halt sequencing errors show within one cycle of frame_busy falling: control reads 0x05 while the halt waits and 0x01 once it is confirmed, and status bit7 rises at that point.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int CNT_W = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          ev_rx_ok,
  input  logic          ev_tx_ok,
  input  logic          ev_rx_err,
  input  logic          ev_tx_err,
  input  logic          ev_ring_ovw,
  input  logic          ev_xfer_done,
  input  logic          tally_align,
  input  logic          tally_crc,
  input  logic          tally_miss,
  input  logic          frame_busy,
  input  logic          ring_freed,
  output logic          irq,
  output logic          running
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_MASK = AW'(2);
  localparam logic [AW-1:0] A_TAL0 = AW'(3);
  localparam logic [AW-1:0] A_TAL1 = AW'(4);
  localparam logic [AW-1:0] A_TAL2 = AW'(5);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [6:0]       stat;
  logic [6:0]       mask;
  logic             run;
  logic             halt_wait;
  logic             halt_flag;
  logic             ovw_flag;
  logic [CNT_W-1:0] tally [3];

  wire wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  wire wr_stat = bus_wr && (bus_addr == A_STAT);
  wire wr_mask = bus_wr && (bus_addr == A_MASK);
  wire halt_cmd  = wr_ctrl && bus_wdata[0];
  wire start_cmd = wr_ctrl && bus_wdata[1] && !bus_wdata[0];

  wire [2:0] t_inc = {tally_miss, tally_crc, tally_align};
  wire [2:0] t_rd  = {bus_rd && (bus_addr == A_TAL2),
                      bus_rd && (bus_addr == A_TAL1),
                      bus_rd && (bus_addr == A_TAL0)};
  wire any_top = tally[0][CNT_W-1] | tally[1][CNT_W-1] | tally[2][CNT_W-1];

  wire [6:0] ev_vec  = {ev_xfer_done, any_top, ev_ring_ovw, ev_tx_err,
                        ev_rx_err, ev_tx_ok, ev_rx_ok};
  wire [6:0] clr_vec = wr_stat ? bus_wdata[6:0] : 7'd0;
  wire       rst_bit = halt_flag | ovw_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr_vec) | ev_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (wr_mask) mask <= bus_wdata[6:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      halt_wait <= 1'b0;
      halt_flag <= 1'b1;
    end else if (halt_cmd) begin
      run       <= 1'b0;
      halt_wait <= 1'b1;
    end else if (start_cmd) begin
      run       <= 1'b1;
      halt_wait <= 1'b0;
      halt_flag <= 1'b0;
    end else if (halt_wait && !frame_busy) begin
      halt_wait <= 1'b0;
      halt_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ovw_flag <= 1'b0;
    else if (ev_ring_ovw)              ovw_flag <= 1'b1;
    else if (start_cmd || ring_freed)  ovw_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) tally[i] <= '0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (t_rd[i])                            tally[i] <= t_inc[i] ? CNT_W'(1) : '0;
        else if (t_inc[i] && tally[i] != CNT_TOP) tally[i] <= tally[i] + 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {5'd0, halt_wait, run, ~run};
      A_STAT:  bus_rdata = {rst_bit, stat};
      A_MASK:  bus_rdata = {1'b0, mask};
      A_TAL0:  bus_rdata = 8'(tally[0]);
      A_TAL1:  bus_rdata = 8'(tally[1]);
      A_TAL2:  bus_rdata = 8'(tally[2]);
      default: bus_rdata = 8'd0;
    endcase
  end

  assign irq     = |(stat & mask);
  assign running = run;

  // R2
  rxok_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_ok |=> stat[0]);
  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_ok && wr_stat && bus_wdata[1]) |=> stat[1]);
  // R4
  mask_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_MASK) |-> (bus_rdata[7] == 1'b0));
  // R5
  txe_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_err && mask[3] && !wr_mask) |=> irq);
  // R6
  tally_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tally[2] == CNT_TOP && !t_rd[2]) |=> (tally[2] == CNT_TOP));
  // R8
  top_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_top |=> stat[5]);
  // R9
  start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !ev_ring_ovw) |=> (running && !bus_rdata[7] || bus_addr != A_STAT));
  // R10
  halt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_cmd |=> !running);
endmodule

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic ev_rx_ok = 0, ev_tx_ok = 0, ev_rx_err = 0, ev_tx_err = 0;
  logic ev_ring_ovw = 0, ev_xfer_done = 0;
  logic tally_align = 0, tally_crc = 0, tally_miss = 0;
  logic frame_busy = 0, ring_freed = 0;
  logic irq, running;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  irq_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_rx_ok(ev_rx_ok), .ev_tx_ok(ev_tx_ok), .ev_rx_err(ev_rx_err),
    .ev_tx_err(ev_tx_err), .ev_ring_ovw(ev_ring_ovw), .ev_xfer_done(ev_xfer_done),
    .tally_align(tally_align), .tally_crc(tally_crc), .tally_miss(tally_miss),
    .frame_busy(frame_busy), .ring_freed(ring_freed), .irq(irq), .running(running)
  );

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rdchk(input string tag, input logic [2:0] a, input int exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic t_reset;
    // R1
    rdchk("R1 status", 1, 8'h80);
    rdchk("R1 mask", 2, 8'h00);
    rdchk("R1 ctrl", 0, 8'h01);
    rdchk("R1 tally0", 3, 0);
    rdchk("R1 tally1", 4, 0);
    rdchk("R1 tally2", 5, 0);
    check("R1 irq", irq, 0);
    check("R1 running", running, 0);
  endtask

  task automatic t_start;
    // R9
    wr(0, 8'h02);
    rdchk("R9 status", 1, 8'h00);
    rdchk("R9 ctrl", 0, 8'h02);
    check("R9 running", running, 1);
  endtask

  task automatic t_events;
    // R2
    pulse(ev_rx_ok);     rdchk("R2 rx_ok", 1, 8'h01);
    pulse(ev_tx_ok);     rdchk("R2 tx_ok", 1, 8'h03);
    pulse(ev_rx_err);    rdchk("R2 rx_err", 1, 8'h07);
    pulse(ev_tx_err);    rdchk("R2 tx_err", 1, 8'h0F);
    pulse(ev_xfer_done); rdchk("R2 xfer_done", 1, 8'h4F);
    check("R5 irq masked off", irq, 0);
  endtask

  task automatic t_w1c;
    // R3
    wr(1, 8'h00); rdchk("R3 write zero", 1, 8'h4F);
    wr(1, 8'h80); rdchk("R3 write bit7", 1, 8'h4F);
    wr(1, 8'h05); rdchk("R3 partial clear", 1, 8'h4A);
    @(negedge clk); bus_wr = 1; bus_addr = 1; bus_wdata = 8'h02; ev_tx_ok = 1;
    @(negedge clk); bus_wr = 0; ev_tx_ok = 0;
    rdchk("R3 set wins", 1, 8'h4A);
    wr(1, 8'h7F); rdchk("R3 clear all", 1, 8'h00);
  endtask

  task automatic t_mask;
    // R4 R5
    wr(2, 8'hFF); rdchk("R4 mask bit7", 2, 8'h7F);
    check("R5 no status no irq", irq, 0);
    pulse(ev_rx_err);
    check("R5 irq on rx_err", irq, 1);
    wr(2, 8'h00);
    check("R5 irq masked", irq, 0);
    wr(2, 8'h04);
    check("R5 irq unmasked", irq, 1);
    wr(1, 8'h04);
    check("R5 irq after clear", irq, 0);
    wr(2, 8'h7F); rdchk("R4 mask readback", 2, 8'h7F);
  endtask

  task automatic t_tally;
    logic [7:0] v;
    // R6 R7
    repeat (3) pulse(tally_align);
    rdchk("R6 align count", 3, 3);
    rdchk("R7 cleared on read", 3, 0);
    repeat (2) pulse(tally_crc);
    @(negedge clk); bus_rd = 1; bus_addr = 4; tally_crc = 1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0; tally_crc = 0;
    check("R7 read with inc value", v, 2);
    rdchk("R7 inc during read", 4, 1);
    // R8 stays clear below the top bit
    rdchk("R8 no overflow yet", 1, 8'h00);
    @(negedge clk); tally_miss = 1;
    repeat (300) @(negedge clk);
    tally_miss = 0;
    rdchk("R8 overflow bit", 1, 8'h20);
    check("R8 overflow irq", irq, 1);
    wr(1, 8'h20); rdchk("R8 clear blocked", 1, 8'h20);
    rdchk("R6 saturated", 5, 8'hFF);
    rdchk("R7 missed cleared", 5, 0);
    wr(1, 8'h20); rdchk("R8 clear after read", 1, 8'h00);
    check("R8 irq gone", irq, 0);
  endtask

  task automatic t_halt;
    // R10
    @(negedge clk); frame_busy = 1;
    wr(0, 8'h01);
    check("R10 running drops", running, 0);
    rdchk("R10 ctrl pending", 0, 8'h05);
    repeat (5) @(negedge clk);
    rdchk("R10 bit7 waits", 1, 8'h00);
    frame_busy = 0;
    @(negedge clk);
    rdchk("R10 bit7 set", 1, 8'h80);
    rdchk("R10 ctrl halted", 0, 8'h01);
    check("R5 bit7 no irq", irq, 0);
    // R11 freeing does not clear a confirmed halt
    pulse(ring_freed);
    rdchk("R11 halt kept", 1, 8'h80);
    wr(0, 8'h02);
    rdchk("R9 restart clears", 1, 8'h00);
  endtask

  task automatic t_ovw;
    // R11
    pulse(ev_ring_ovw);
    rdchk("R11 overwrite", 1, 8'h90);
    check("R11 irq", irq, 1);
    pulse(ring_freed);
    rdchk("R11 freed", 1, 8'h10);
    check("R11 still running", running, 1);
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: got=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_start();
    t_events();
    t_w1c();
    t_mask();
    t_tally();
    t_halt();
    t_ovw();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule